// File: doc/BRIEF.md
# Output Denormalization Clamp

This block turns normalized pixel components into integer codes at the bit depth a display pipe sends out. Each of three colour channels arrives as a 16-bit unsigned fraction, where 0 stands for black and 0xFFFF for just under full scale. A per-pixel mode picks the target depth: 8, 10 or 12 bits, or a plain truncation. For the three scaled depths the component is multiplied by exactly (2^n-1)/2^n, rounded to n bits and saturated, so full scale lands on the largest code and never wraps.

A second control bit re-expresses whatever depth was chosen in a 10-bit output format. Mode and format are captured together with each valid pixel. A reconfiguration therefore takes effect on a pixel boundary and never splits a pixel. The result appears two clock cycles after the input, with a matching valid. Between results the outputs hold the last value.

Top module: `denorm_clamp`

## Requirements
- R1: While reset is asserted and after its release until the first result, out_valid is 0 and all three output channels are 0.
- R2: Each cycle with in_valid high yields exactly one cycle with out_valid high, two clock edges later; out_valid is never high otherwise.
- R3: With cfg_mode = 1 (8-bit depth), each channel gives min(255, (x - floor(x/256) + 128) >> 8) for input x.
- R4: With cfg_mode = 2 (10-bit depth), each channel gives min(1023, (x - floor(x/1024) + 32) >> 6).
- R5: With cfg_mode = 3 (12-bit depth), each channel gives min(4095, (x - floor(x/4096) + 8) >> 4).
- R6: With cfg_mode = 0 (pass), each channel gives x >> 4, the upper 12 bits of the input, with no scaling or rounding.
- R7: No result exceeds 2^n-1 for its depth n (n = 12 in pass mode), and an input of 0xFFFF gives exactly 2^n-1.
- R8: With cfg_out10 = 1, a depth-n result v is presented as v << (10-n) when n < 10, as v when n = 10 and as v >> (n-10) when n > 10; output bits 11 and 10 are then 0.
- R9: cfg_mode and cfg_out10 are taken only in cycles where in_valid is high; a change while in_valid is low, or between back-to-back pixels, affects only the pixels accepted with it.
- R10: While out_valid is low, all output channels keep their previous value.
- R11: The three channels are computed independently; each output depends only on its own input and the shared configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Depth select: 0 pass, 1 8-bit, 2 10-bit, 3 12-bit |
| cfg_out10 | input | 1 | Present the result in 10-bit format |
| in_valid | input | 1 | Input pixel qualifier |
| in_ch0 | input | 16 | Channel 0 normalized component |
| in_ch1 | input | 16 | Channel 1 normalized component |
| in_ch2 | input | 16 | Channel 2 normalized component |
| out_valid | output | 1 | Result qualifier, two cycles after in_valid |
| out_ch0 | output | 12 | Channel 0 result |
| out_ch1 | output | 12 | Channel 1 result |
| out_ch2 | output | 12 | Channel 2 result |

## Verification
The hardest cases to reach are the rounding thresholds. These are inputs where the half-LSB rounding term just carries into the result, such as 0x0080 against 0x007F at 8 bits, 0x0020 against 0x001F at 10 bits and 0x0008 against 0x0007 at 12 bits. Random data almost never lands on them, so the stimulus sends each pair directly in every mode. Full scale 0xFFFF is sent in every mode, with and without the 10-bit format, to exercise the saturation bound. Back-to-back pixels alternate modes while the configuration is scrambled during idle cycles, which shows that the configuration travels with each pixel.

// File: rtl/denorm_pkg.sv
package denorm_pkg;

  localparam int DN_NCH  = 3;
  localparam int DN_FMT10 = 10;

  typedef enum logic [1:0] {
    DN_PASS = 2'd0,
    DN_D8   = 2'd1,
    DN_D10  = 2'd2,
    DN_D12  = 2'd3
  } dn_mode_e;

  typedef struct packed {
    logic     out10;
    dn_mode_e mode;
  } dn_cfg_t;

  // Target depth in bits; pass mode truncates to the full output width.
  function automatic int unsigned dn_depth(dn_mode_e m, int unsigned pass_w);
    int unsigned d;
    case (m)
      DN_D8:   d = 8;
      DN_D10:  d = 10;
      DN_D12:  d = 12;
      default: d = pass_w;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/denorm_cfg_pipe.sv
module denorm_cfg_pipe
  import denorm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  dn_cfg_t in_cfg,
  output logic    s1_valid,
  output dn_cfg_t s1_cfg,
  output logic    s2_valid
);

  logic    s1_valid_n;
  logic    s2_valid_n;
  dn_cfg_t s1_cfg_n;

  always_comb begin
    s1_valid_n = in_valid;
    s2_valid_n = s1_valid;
    s1_cfg_n   = in_valid ? in_cfg : s1_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
      s1_cfg   <= '0;
    end else begin
      s1_valid <= s1_valid_n;
      s2_valid <= s2_valid_n;
      s1_cfg   <= s1_cfg_n;
    end
  end

endmodule

// File: rtl/denorm_scale.sv
module denorm_scale
  import denorm_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  dn_mode_e        mode,
  input  logic [IN_W-1:0] x,
  output logic [IN_W:0]   sum_q
);

  int unsigned     depth;
  logic [IN_W-1:0] shifted;
  logic [IN_W-1:0] scaled;
  logic [IN_W:0]   rnd;
  logic [IN_W:0]   sum_d;
  logic [IN_W:0]   sum_n;

  // x * (2^n - 1) / 2^n expressed as x - x/2^n, plus half an output LSB.
  always_comb begin
    depth = dn_depth(mode, OUT_W);
    rnd   = '0;
    if (mode == DN_PASS) begin
      shifted = '0;
    end else begin
      shifted = x >> depth;
      rnd[IN_W-1-depth] = 1'b1;
    end
    scaled = x - shifted;
    sum_d  = {1'b0, scaled} + rnd;
    sum_n  = en ? sum_d : sum_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_n;
  end

endmodule

// File: rtl/denorm_fmt.sv
module denorm_fmt
  import denorm_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  dn_cfg_t          cfg,
  input  logic [IN_W:0]    sum,
  output logic [OUT_W-1:0] pix_q
);

  localparam logic [OUT_W-1:0] ALL1 = '1;

  int unsigned      depth;
  logic [IN_W:0]    q;
  logic [OUT_W-1:0] maxv;
  logic             over;
  logic [OUT_W-1:0] sat;
  logic [OUT_W-1:0] pix_d;
  logic [OUT_W-1:0] pix_n;

  always_comb begin
    depth = dn_depth(cfg.mode, OUT_W);
    q     = sum >> (IN_W - depth);
    maxv  = ~(ALL1 << depth);
    over  = (|q[IN_W:OUT_W]) || (q[OUT_W-1:0] > maxv);
    sat   = over ? maxv : q[OUT_W-1:0];
    if (cfg.out10) begin
      if (depth > DN_FMT10) pix_d = sat >> (depth - DN_FMT10);
      else                  pix_d = sat << (DN_FMT10 - depth);
    end else begin
      pix_d = sat;
    end
    pix_n = en ? pix_d : pix_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_q <= '0;
    else        pix_q <= pix_n;
  end

endmodule

// File: rtl/denorm_clamp.sv
module denorm_clamp
  import denorm_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_out10,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_ch0,
  input  logic [IN_W-1:0]  in_ch1,
  input  logic [IN_W-1:0]  in_ch2,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_ch0,
  output logic [OUT_W-1:0] out_ch1,
  output logic [OUT_W-1:0] out_ch2
);

  dn_cfg_t          in_cfg;
  dn_cfg_t          s1_cfg;
  logic             s1_valid;
  logic [IN_W-1:0]  in_arr  [DN_NCH];
  logic [IN_W:0]    sum_arr [DN_NCH];
  logic [OUT_W-1:0] out_arr [DN_NCH];

  always_comb begin
    in_cfg.out10 = cfg_out10;
    in_cfg.mode  = dn_mode_e'(cfg_mode);
  end

  assign in_arr[0] = in_ch0;
  assign in_arr[1] = in_ch1;
  assign in_arr[2] = in_ch2;

  denorm_cfg_pipe u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_cfg   (in_cfg),
    .s1_valid (s1_valid),
    .s1_cfg   (s1_cfg),
    .s2_valid (out_valid)
  );

  for (genvar c = 0; c < DN_NCH; c++) begin : g_ch
    denorm_scale #(.IN_W(IN_W), .OUT_W(OUT_W)) u_scale (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_valid),
      .mode  (in_cfg.mode),
      .x     (in_arr[c]),
      .sum_q (sum_arr[c])
    );
    denorm_fmt #(.IN_W(IN_W), .OUT_W(OUT_W)) u_fmt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (s1_valid),
      .cfg   (s1_cfg),
      .sum   (sum_arr[c]),
      .pix_q (out_arr[c])
    );
  end

  assign out_ch0 = out_arr[0];
  assign out_ch1 = out_arr[1];
  assign out_ch2 = out_arr[2];

endmodule

// File: rtl/denorm_clamp_chk.sv
module denorm_clamp_chk #(
  parameter int OUT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_mode,
  input logic             cfg_out10,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_ch0,
  input logic [OUT_W-1:0] out_ch1,
  input logic [OUT_W-1:0] out_ch2
);

  // Shadow of the configuration seen two edges back, captured with in_valid.
  logic [1:0]       m1, m2;
  logic             f1, f2;
  logic [OUT_W-1:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= '0; m2 <= '0; f1 <= 1'b0; f2 <= 1'b0;
    end else begin
      m1 <= cfg_mode;  m2 <= m1;
      f1 <= cfg_out10; f2 <= f1;
    end
  end

  always_comb begin
    if (f2) lim = OUT_W'(1023);
    else begin
      case (m2)
        2'd1:    lim = OUT_W'(255);
        2'd2:    lim = OUT_W'(1023);
        2'd3:    lim = OUT_W'(4095);
        default: lim = '1;
      endcase
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_ch0 == '0 && out_ch1 == '0 && out_ch2 == '0));

  a_r2_latency_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  a_r2_latency_back: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ch0 <= lim && out_ch1 <= lim && out_ch2 <= lim));

  a_r8_fmt10_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && f2) |-> ((out_ch0 >> 10) == '0 && (out_ch1 >> 10) == '0 && (out_ch2 >> 10) == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_ch0) && $stable(out_ch1) && $stable(out_ch2)));

endmodule

bind denorm_clamp denorm_clamp_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_mode  (cfg_mode),
  .cfg_out10 (cfg_out10),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_ch0   (out_ch0),
  .out_ch1   (out_ch1),
  .out_ch2   (out_ch2)
);

// File: tb/denorm_clamp_test.sv
module denorm_clamp_test;

  logic        clk;
  logic        rst_n;
  logic [1:0]  cfg_mode;
  logic        cfg_out10;
  logic        in_valid;
  logic [15:0] in_ch0, in_ch1, in_ch2;
  logic        out_valid;
  logic [11:0] out_ch0, out_ch1, out_ch2;

  int checks;
  int fails;
  logic [35:0] exp_q [$];
  string       tag_q [$];
  logic [35:0] last_out;

  denorm_clamp uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_out10(cfg_out10),
    .in_valid(in_valid), .in_ch0(in_ch0), .in_ch1(in_ch1), .in_ch2(in_ch2),
    .out_valid(out_valid), .out_ch0(out_ch0), .out_ch1(out_ch1), .out_ch2(out_ch2)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Expected result from the requirement formulas (R3..R8).
  function automatic logic [11:0] model(input int m, input bit f, input int x);
    int n, v;
    if (m == 0) begin
      n = 12; v = x >> 4;
    end else begin
      n = 6 + 2 * m;
      v = (x - (x >> n) + (1 << (15 - n))) >> (16 - n);
      if (v > (1 << n) - 1) v = (1 << n) - 1;
    end
    if (f) v = (n > 10) ? (v >> (n - 10)) : (v << (10 - n));
    return v[11:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(input int m, input bit f, input logic [15:0] a,
                      input logic [15:0] b, input logic [15:0] c, input string tag);
    @(negedge clk);
    cfg_mode  = m[1:0];
    cfg_out10 = f;
    in_ch0 = a; in_ch1 = b; in_ch2 = c;
    in_valid = 1'b1;
    exp_q.push_back({model(m, f, c), model(m, f, b), model(m, f, a)});
    tag_q.push_back(tag);
  endtask

  // Idle cycles with scrambled configuration (R9: must be ignored).
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      cfg_mode  = cfg_mode + 2'd1;
      cfg_out10 = ~cfg_out10;
      in_ch0 = in_ch0 ^ 16'h5A5A;
    end
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected out_valid", {out_ch2, out_ch1, out_ch0}, '0);
      end else begin
        logic [35:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({out_ch2, out_ch1, out_ch0} == e, t, "pixel", {out_ch2, out_ch1, out_ch0}, e);
        last_out = {out_ch2, out_ch1, out_ch0};
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    checks = 0; fails = 0;
    rst_n = 1'b0; in_valid = 1'b0; cfg_mode = 2'd0; cfg_out10 = 1'b0;
    in_ch0 = '0; in_ch1 = '0; in_ch2 = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && {out_ch2, out_ch1, out_ch0} == '0, "R1", "in reset",
          {35'd0, out_valid}, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && {out_ch2, out_ch1, out_ch0} == '0, "R1", "after release",
          {out_ch2, out_ch1, out_ch0}, '0);

    // R2: explicit latency of one pixel.
    send(1, 0, 16'h8000, 16'h4000, 16'h0100, "R2");
    @(negedge clk); in_valid = 1'b0;
    check(!out_valid, "R2", "one edge after", {35'd0, out_valid}, '0);
    @(negedge clk);
    check(out_valid, "R2", "two edges after", {35'd0, out_valid}, 36'd1);
    idle(3);

    // R3, R4, R5: rounding thresholds per depth.
    send(1, 0, 16'h007F, 16'h0080, 16'h1234, "R3");
    send(2, 0, 16'h001F, 16'h0020, 16'hABCD, "R4");
    send(3, 0, 16'h0007, 16'h0008, 16'h7FFF, "R5");
    // R6: pass mode truncation.
    send(0, 0, 16'h1234, 16'hFFFF, 16'h000F, "R6");
    // R7: full scale and zero in every depth.
    send(1, 0, 16'hFFFF, 16'h0000, 16'hFF80, "R7");
    send(2, 0, 16'hFFFF, 16'h0000, 16'hFFE0, "R7");
    send(3, 0, 16'hFFFF, 16'h0000, 16'hFFF8, "R7");
    // R8: 10-bit presentation of each depth.
    send(1, 1, 16'hFFFF, 16'h8000, 16'h0080, "R8");
    send(2, 1, 16'hFFFF, 16'h8000, 16'h0020, "R8");
    send(3, 1, 16'hFFFF, 16'h8000, 16'h0008, "R8");
    send(0, 1, 16'h1234, 16'hFFFF, 16'h0040, "R8");
    idle(4);
    // R10: outputs hold the last result while out_valid is low.
    check(!out_valid && {out_ch2, out_ch1, out_ch0} == last_out, "R10", "hold",
          {out_ch2, out_ch1, out_ch0}, last_out);

    // R9: back-to-back pixels with alternating configuration.
    send(1, 0, 16'hC000, 16'hC000, 16'hC000, "R9");
    send(3, 1, 16'hC000, 16'hC000, 16'hC000, "R9");
    send(2, 0, 16'hC000, 16'hC000, 16'hC000, "R9");
    send(0, 1, 16'hC000, 16'hC000, 16'hC000, "R9");
    idle(2);
    send(3, 0, 16'h0123, 16'h4567, 16'h89AB, "R9");
    idle(4);
    check(!out_valid && {out_ch2, out_ch1, out_ch0} == last_out, "R10", "hold after burst",
          {out_ch2, out_ch1, out_ch0}, last_out);

    // R11: independent pseudo-random channels across all settings.
    lf = 16'hACE1;
    for (int i = 0; i < 240; i++) begin
      logic [15:0] a, b, c;
      lf = lf ^ (lf << 7); lf = lf ^ (lf >> 9); lf = lf ^ (lf << 8); a = lf;
      lf = lf ^ (lf << 7); lf = lf ^ (lf >> 9); lf = lf ^ (lf << 8); b = lf;
      lf = lf ^ (lf << 7); lf = lf ^ (lf >> 9); lf = lf ^ (lf << 8); c = lf;
      send(i % 4, ((i / 4) % 2) == 1, a, b, c, "R11");
      if (i % 7 == 6) idle(1);
    end
    idle(6);
    check(exp_q.size() == 0, "R2", "all results delivered",
          36'(exp_q.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule